// File: doc/BRIEF.md
# SAR Converter Conversion Controller

This block is the digital sequencer of a 14-bit successive-approximation analog-to-digital converter. A falling edge on an active-low start input launches a conversion. The block then walks a trial code from the top bit down to the bottom bit and presents it to an external capacitive DAC. On each conversion clock tick it reads a comparator decision, keeps or drops the bit under test, and moves to the next bit. When the last bit is decided, the code is stored in a result shift register and the busy flag returns high.

The conversion clock comes from an internal divider of the system clock, or from an external pin. Holding that pin high picks the internal divider. Toggling it makes each of its rising edges one bit decision. The result is read out serially, most significant bit first, one bit per falling edge of a data clock. The read input turns the serial driver on. A low shutdown input in idle parks the block in a light (nap) or deep (sleep) power state. The choice between them is made by the read level at that moment. All pin inputs are asynchronous and are synchronised to the system clock inside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts only on a falling edge of `conv_start_n`. Holding it low starts exactly one conversion, and a rising edge starts none.
- R2: At the start of a conversion the code register is cleared. The first trial code shown on `trial_code` is 14'h2000 (only the top bit set).
- R3: Start edges that arrive during a conversion are ignored. In internal clock mode a conversion keeps `busy` low for between 13*INT_DIV+2 and 14*INT_DIV+1 system clock cycles.
- R4: Bits are decided from bit 13 down to bit 0, one per conversion clock tick. A bit stays 1 when `cmp_high` is 1 at its tick, so the final code equals the largest code not above the compared input.
- R5: `busy` is low during a conversion. It rises one cycle after the result is stored, so `ser_dout` already carries result bit 13 when `busy` rises.
- R6: When `cclk_pin` has been high for EXT_HIGH_LIMIT cycles, the internal divider ticks every INT_DIV cycles. Otherwise each rising edge of `cclk_pin` is one tick: 13 edges leave the conversion running and the 14th completes it.
- R7: In idle, a low `shutdown_n` enters nap (`pwr_mode` = 1) if `read_n` is low, or sleep (`pwr_mode` = 2) if it is high. Later changes of `read_n` do not change the chosen mode. A high `shutdown_n` returns to active (`pwr_mode` = 0).
- R8: Start edges that arrive while in nap or sleep are ignored and are not remembered after wake-up.
- R9: `ser_dout_en` is 1 while `read_n` is low and 0 while it is high. When it is 0 the serial pin is high impedance.
- R10: `ser_dout` shows result bit 13 first and advances one bit on each falling edge of `data_clk`. After 14 falling edges it reads 0 and stays 0.
- R11: The stored result is kept until the next conversion completes. A readout may run while a new conversion is in progress.
- R12: A low `shutdown_n` during a conversion takes effect only after the conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low start; a falling edge begins a conversion |
| cmp_high | input | 1 | Comparator decision: input at or above the trial code |
| cclk_pin | input | 1 | External conversion clock; held high selects the internal divider |
| shutdown_n | input | 1 | Active-low power-down request |
| read_n | input | 1 | Active-low read: enables the serial driver, picks nap or sleep |
| data_clk | input | 1 | Serial data clock; output advances on its falling edge |
| trial_code | output | 14 | Trial code to the DAC; holds the final code after a conversion |
| busy | output | 1 | Low while a conversion is in progress |
| ser_dout | output | 1 | Serial result bit |
| ser_dout_en | output | 1 | Serial driver enable; 0 means the pin floats |
| pwr_mode | output | 2 | 0 active, 1 nap, 2 sleep |

## Verification
Three stimuli are the hardest to produce from the ports: a second start edge in the middle of a conversion, a shutdown request in the middle of a conversion, and a readout that runs alongside a new conversion. A restart that was wrongly accepted would still convert the same held input, so the result alone would not reveal it. The bench therefore measures how long `busy` stays low and checks it against the divider window. For the overlap case, the bench starts a conversion and immediately clocks out all 14 bits of the previous result with a fast data clock, finishing well inside the shortest possible conversion time. External clock mode is covered by counting the pin edges by hand and checking `busy` after the 13th edge and after the 14th.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_NAP    = 2'd1,
        PWR_SLEEP  = 2'd2
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CONV   = 3'd1,
        ST_FINISH = 3'd2,
        ST_NAP    = 3'd3,
        ST_SLEEP  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sar_in_sync.sv
// Two-stage synchroniser for asynchronous pins; the low EDGE_W bits also
// get a delayed copy so the parent can form edges.
module sar_in_sync #(
    parameter int            W       = 5,
    parameter int            EDGE_W  = 3,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pins_i,
    output logic [W-1:0]      lvl_o,
    output logic [EDGE_W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0]      meta;
        logic [W-1:0]      lvl;
        logic [EDGE_W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pins_i;
        sync_d.lvl  = sync_q.meta;
        sync_d.prev = sync_q.lvl[EDGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{meta: RST_VAL, lvl: RST_VAL, prev: RST_VAL[EDGE_W-1:0]};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.lvl;
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/sar_clk_sel.sv
// Conversion clock tick: internal divider or rising edges of the pin.
module sar_clk_sel #(
    parameter int INT_DIV        = 8,
    parameter int EXT_HIGH_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl_i,
    input  logic pin_rise_i,
    output logic tick_o
);

    localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam int HW = $clog2(EXT_HIGH_LIMIT + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);
    localparam logic [HW-1:0] HIGH_MAX = HW'(EXT_HIGH_LIMIT);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [HW-1:0] high_cnt;
    } clk_t;

    clk_t clk_d, clk_q;
    logic int_tick;
    logic int_sel;

    always_comb begin
        clk_d    = clk_q;
        int_tick = (clk_q.div == DIV_LAST);
        clk_d.div = int_tick ? '0 : clk_q.div + 1'b1;
        if (!pin_lvl_i) begin
            clk_d.high_cnt = '0;
        end else if (clk_q.high_cnt != HIGH_MAX) begin
            clk_d.high_cnt = clk_q.high_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '{div: '0, high_cnt: '0};
        end else begin
            clk_q <= clk_d;
        end
    end

    assign int_sel = (clk_q.high_cnt == HIGH_MAX);
    assign tick_o  = int_sel ? int_tick : pin_rise_i;

    generate
        if (INT_DIV > 1) begin : g_gap_chk
            // R6: internal ticks never come on adjacent cycles
            assert_int_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && int_sel) |=> !(tick_o && int_sel));
        end
    endgenerate

endmodule

// File: rtl/sar_seq.sv
// Successive-approximation sequencer and power-state control.
module sar_seq
    import sar_conv_pkg::*;
#(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_fall_i,
    input  logic           tick_i,
    input  logic           cmp_i,
    input  logic           shdn_lvl_i,
    input  logic           read_lvl_i,
    output logic [RES-1:0] trial_o,
    output logic           busy_o,
    output logic           res_load_o,
    output logic [RES-1:0] res_code_o,
    output pwr_mode_e      pwr_mode_o
);

    localparam int IW = $clog2(RES);
    localparam logic [IW-1:0]  TOP_IDX = IW'(RES - 1);
    localparam logic [RES-1:0] MSB_ONE = {1'b1, {(RES-1){1'b0}}};

    typedef struct packed {
        seq_state_e     st;
        logic [RES-1:0] sar;
        logic [IW-1:0]  idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [RES-1:0] decided;
    logic [RES-1:0] next_trial;
    logic           load;

    always_comb begin
        seq_d      = seq_q;
        load       = 1'b0;
        decided    = seq_q.sar;
        decided[seq_q.idx] = cmp_i;
        next_trial = decided;
        next_trial[seq_q.idx - 1'b1] = 1'b1;
        case (seq_q.st)
            ST_IDLE: begin
                if (!shdn_lvl_i) begin
                    seq_d.st = read_lvl_i ? ST_SLEEP : ST_NAP;
                end else if (start_fall_i) begin
                    seq_d.st  = ST_CONV;
                    seq_d.sar = MSB_ONE;
                    seq_d.idx = TOP_IDX;
                end
            end
            ST_CONV: begin
                if (tick_i) begin
                    if (seq_q.idx == '0) begin
                        seq_d.sar = decided;
                        seq_d.st  = ST_FINISH;
                        load      = 1'b1;
                    end else begin
                        seq_d.sar = next_trial;
                        seq_d.idx = seq_q.idx - 1'b1;
                    end
                end
            end
            ST_FINISH: seq_d.st = ST_IDLE;
            ST_NAP, ST_SLEEP: begin
                if (shdn_lvl_i) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, sar: '0, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign trial_o    = seq_q.sar;
    assign busy_o     = !(seq_q.st == ST_CONV || seq_q.st == ST_FINISH);
    assign res_load_o = load;
    assign res_code_o = decided;
    assign pwr_mode_o = (seq_q.st == ST_NAP)   ? PWR_NAP :
                        (seq_q.st == ST_SLEEP) ? PWR_SLEEP : PWR_ACTIVE;

    // R2: every conversion opens with only the top bit on trial
    assert_first_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (trial_o == MSB_ONE));

    // R3: while busy stays low the bit index never jumps back up
    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> (seq_q.idx <= $past(seq_q.idx)));

    // R5: busy rises only after a cycle spent with the result stored
    assert_busy_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(seq_q.st == ST_FINISH));

    // R12: a running conversion is never cut short by shutdown
    assert_shdn_deferred_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CONV) |=> (pwr_mode_o == PWR_ACTIVE));

endmodule

// File: rtl/sar_shift_out.sv
// Result register and serial shifter, MSB first, zero fill.
module sar_shift_out #(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [RES-1:0] code_i,
    input  logic           shift_i,
    output logic           bit_o
);

    typedef struct packed {
        logic [RES-1:0] sh;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.sh = code_i;
        end else if (shift_i) begin
            shf_d.sh = {shf_q.sh[RES-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '{sh: '0};
        end else begin
            shf_q <= shf_d;
        end
    end

    assign bit_o = shf_q.sh[RES-1];

    // R10: each data clock fall moves the word up by one place
    assert_shift_msb_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (shf_q.sh == {$past(shf_q.sh[RES-2:0]), 1'b0}));

    // R10: once emptied the register keeps reading zero until reloaded
    assert_zero_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((shf_q.sh == '0) && !load_i) |=> (shf_q.sh == '0));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES            = 14,
    parameter int INT_DIV        = 8,
    parameter int EXT_HIGH_LIMIT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_start_n,
    input  logic           cmp_high,
    input  logic           cclk_pin,
    input  logic           shutdown_n,
    input  logic           read_n,
    input  logic           data_clk,
    output logic [RES-1:0] trial_code,
    output logic           busy,
    output logic           ser_dout,
    output logic           ser_dout_en,
    output logic [1:0]     pwr_mode
);

    localparam int PIN_W  = 5;
    localparam int EDGE_W = 3;
    // bit order: 0 start, 1 conversion clock pin, 2 data clock, 3 shutdown, 4 read
    localparam logic [PIN_W-1:0] PIN_RST = 5'b11011;

    logic [PIN_W-1:0]  pins;
    logic [PIN_W-1:0]  pin_lvl;
    logic [EDGE_W-1:0] pin_prev;
    logic              start_fall;
    logic              cclk_rise;
    logic              dclk_fall;
    logic              tick;
    logic              res_load;
    logic [RES-1:0]    res_code;
    pwr_mode_e         pmode;

    assign pins = {read_n, shutdown_n, data_clk, cclk_pin, conv_start_n};

    sar_in_sync #(.W(PIN_W), .EDGE_W(EDGE_W), .RST_VAL(PIN_RST)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .lvl_o  (pin_lvl),
        .prev_o (pin_prev)
    );

    assign start_fall = pin_prev[0] & ~pin_lvl[0];
    assign cclk_rise  = ~pin_prev[1] & pin_lvl[1];
    assign dclk_fall  = pin_prev[2] & ~pin_lvl[2];

    sar_clk_sel #(.INT_DIV(INT_DIV), .EXT_HIGH_LIMIT(EXT_HIGH_LIMIT)) i_clk_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl_i  (pin_lvl[1]),
        .pin_rise_i (cclk_rise),
        .tick_o     (tick)
    );

    sar_seq #(.RES(RES)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_fall_i (start_fall),
        .tick_i       (tick),
        .cmp_i        (cmp_high),
        .shdn_lvl_i   (pin_lvl[3]),
        .read_lvl_i   (pin_lvl[4]),
        .trial_o      (trial_code),
        .busy_o       (busy),
        .res_load_o   (res_load),
        .res_code_o   (res_code),
        .pwr_mode_o   (pmode)
    );

    sar_shift_out #(.RES(RES)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (res_load),
        .code_i  (res_code),
        .shift_i (dclk_fall),
        .bit_o   (ser_dout)
    );

    assign ser_dout_en = ~pin_lvl[4];
    assign pwr_mode    = pmode;

    // R8: no conversion can be running while powered down
    assert_no_conv_in_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != PWR_ACTIVE) |-> busy);

endmodule

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;

    localparam int RES = 14;
    localparam int DIV = 12;
    localparam int LIM = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           conv_start_n = 1'b1;
    logic           cclk_pin = 1'b1;
    logic           shutdown_n = 1'b1;
    logic           read_n = 1'b1;
    logic           data_clk = 1'b0;
    logic [RES-1:0] vin = '0;
    logic           cmp_high;
    logic [RES-1:0] trial_code;
    logic           busy;
    logic           ser_dout;
    logic           ser_dout_en;
    logic [1:0]     pwr_mode;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    bit dur_on = 1'b1;
    logic [RES-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    // ideal comparator standing in for the analog path
    assign cmp_high = (vin >= trial_code);

    sar_conv_ctrl #(.RES(RES), .INT_DIV(DIV), .EXT_HIGH_LIMIT(LIM)) i_sar_conv_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_n (conv_start_n),
        .cmp_high     (cmp_high),
        .cclk_pin     (cclk_pin),
        .shutdown_n   (shutdown_n),
        .read_n       (read_n),
        .data_clk     (data_clk),
        .trial_code   (trial_code),
        .busy         (busy),
        .ser_dout     (ser_dout),
        .ser_dout_en  (ser_dout_en),
        .pwr_mode     (pwr_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // driver: launch a conversion and queue its expected code
    task automatic start_conv(input logic [RES-1:0] v);
        vin = v;
        exp_q.push_back(v);
        conv_start_n = 1'b0;
        cyc(4);
        conv_start_n = 1'b1;
    endtask

    task automatic wait_done(input int target);
        int g = 0;
        while (done_cnt < target && g < 3000) begin
            cyc(1);
            g++;
        end
        chk(done_cnt >= target, "R4 conversion completes", done_cnt, target);
    endtask

    task automatic read_bits(input logic [RES-1:0] v, input string tag);
        for (int i = RES - 1; i >= 0; i--) begin
            chk(ser_dout === v[i], tag, ser_dout, v[i]);
            data_clk = 1'b1;
            cyc(3);
            data_clk = 1'b0;
            cyc(4);
        end
    endtask

    // monitor: scores each completed conversion against the queue
    logic prev_busy = 1'b1;
    int   low_cnt = 0;
    always @(negedge clk) begin
        logic [RES-1:0] e;
        if (!rst_n) begin
            prev_busy = 1'b1;
            low_cnt   = 0;
        end else begin
            if (!busy && prev_busy) begin
                low_cnt = 1;
                chk(trial_code == 14'h2000, "R2 first trial code", trial_code, 14'h2000);
            end else if (!busy) begin
                low_cnt++;
            end
            if (busy && !prev_busy) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected completion", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk(trial_code == e, "R4 final code", trial_code, e);
                    chk(ser_dout == e[RES-1], "R5 data valid at busy rise", ser_dout, e[RES-1]);
                end
                if (dur_on) begin
                    chk(low_cnt >= 13*DIV+2 && low_cnt <= 14*DIV+1,
                        "R3 R6 busy low length", low_cnt, 14*DIV+1);
                end
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        logic [RES-1:0] vals [6] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555, 14'h2000, 14'h1FFF};
        cyc(5);
        rst_n = 1'b1;
        cyc(20);
        chk(busy == 1'b1, "R5 reset busy high", busy, 1);
        chk(pwr_mode == 2'd0, "R7 reset active", pwr_mode, 0);
        chk(ser_dout_en == 1'b0, "R9 reset driver off", ser_dout_en, 0);
        chk(ser_dout == 1'b0, "R10 reset serial zero", ser_dout, 0);
        chk(trial_code == '0, "R2 reset code clear", trial_code, 0);

        // R4: several input patterns in internal clock mode
        foreach (vals[k]) begin
            base = done_cnt;
            start_conv(vals[k]);
            wait_done(base + 1);
            cyc(5);
        end

        // R9 R10: full serial readout of the last result
        read_n = 1'b0;
        cyc(4);
        chk(ser_dout_en == 1'b1, "R9 driver on with read low", ser_dout_en, 1);
        read_bits(14'h1FFF, "R10 serial bit");
        chk(ser_dout == 1'b0, "R10 zero after 14 bits", ser_dout, 0);
        data_clk = 1'b1; cyc(3); data_clk = 1'b0; cyc(4);
        chk(ser_dout == 1'b0, "R10 stays zero", ser_dout, 0);
        read_n = 1'b1;
        cyc(4);
        chk(ser_dout_en == 1'b0, "R9 driver off with read high", ser_dout_en, 0);

        // R1: held low starts exactly one conversion; rising edge starts none
        base = done_cnt;
        vin = 14'h0F0F;
        exp_q.push_back(14'h0F0F);
        conv_start_n = 1'b0;
        wait_done(base + 1);
        cyc(30);
        chk(done_cnt == base + 1 && busy, "R1 level held low no second start", done_cnt, base + 1);
        conv_start_n = 1'b1;
        cyc(30);
        chk(busy == 1'b1, "R1 rising edge starts nothing", busy, 1);

        // R3: second start edge mid-conversion is ignored
        base = done_cnt;
        start_conv(14'h1234);
        cyc(56);
        conv_start_n = 1'b0; cyc(4); conv_start_n = 1'b1;
        wait_done(base + 1);
        cyc(200);
        chk(done_cnt == base + 1 && busy, "R3 no restarted conversion", done_cnt, base + 1);

        // R7 R8: nap, mode latch, ignored start, then sleep
        base = done_cnt;
        read_n = 1'b0;
        cyc(4);
        shutdown_n = 1'b0;
        cyc(6);
        chk(pwr_mode == 2'd1, "R7 nap with read low", pwr_mode, 1);
        read_n = 1'b1;
        cyc(6);
        chk(pwr_mode == 2'd1, "R7 mode latched at entry", pwr_mode, 1);
        conv_start_n = 1'b0; cyc(4); conv_start_n = 1'b1;
        cyc(30);
        chk(busy == 1'b1, "R8 start ignored in nap", busy, 1);
        shutdown_n = 1'b1;
        cyc(6);
        chk(pwr_mode == 2'd0, "R7 wake to active", pwr_mode, 0);
        cyc(40);
        chk(busy == 1'b1 && done_cnt == base, "R8 start not remembered", done_cnt, base);
        shutdown_n = 1'b0;
        cyc(6);
        chk(pwr_mode == 2'd2, "R7 sleep with read high", pwr_mode, 2);
        shutdown_n = 1'b1;
        cyc(6);

        // R12: shutdown during a conversion waits for completion
        base = done_cnt;
        start_conv(14'h2345);
        cyc(36);
        shutdown_n = 1'b0;
        cyc(6);
        chk(pwr_mode == 2'd0 && busy == 1'b0, "R12 conversion continues", pwr_mode, 0);
        wait_done(base + 1);
        cyc(6);
        chk(pwr_mode == 2'd2, "R12 sleep after completion", pwr_mode, 2);
        shutdown_n = 1'b1;
        cyc(6);

        // R11: read old result while the next conversion runs
        base = done_cnt;
        start_conv(14'h3A5C);
        wait_done(base + 1);
        cyc(5);
        start_conv(14'h05A3);
        read_n = 1'b0;
        cyc(4);
        read_bits(14'h3A5C, "R11 overlapped readout bit");
        chk(busy == 1'b0, "R11 conversion still running during readout", busy, 0);
        wait_done(base + 2);
        read_n = 1'b1;
        cyc(5);

        // R6: external conversion clock, edge by edge
        dur_on = 1'b0;
        cclk_pin = 1'b0;
        cyc(20);
        base = done_cnt;
        start_conv(14'h2C3B);
        cyc(6);
        for (int p = 0; p < 13; p++) begin
            cclk_pin = 1'b1; cyc(4); cclk_pin = 1'b0; cyc(4);
        end
        cyc(10);
        chk(busy == 1'b0 && done_cnt == base, "R6 13 edges still converting", busy, 0);
        cclk_pin = 1'b1; cyc(4); cclk_pin = 1'b0;
        cyc(10);
        chk(done_cnt == base + 1, "R6 14th edge completes", done_cnt, base + 1);

        // R6: back to the internal divider
        cclk_pin = 1'b1;
        cyc(30);
        dur_on = 1'b1;
        base = done_cnt;
        start_conv(14'h0001);
        wait_done(base + 1);
        cyc(5);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end

endmodule